// File: doc/BRIEF.md
# Multi-lane serial memory interface front end

This block is the host-facing serial port of a small memory device. A host frames each transaction with an active-low select line and clocks it with a serial clock. The first byte selects a command. The command sets how many data lines the address and data phases use: one, two or four. The block collects the address, then either streams bytes out of an internal byte array or gathers bytes into a program buffer. The address keeps advancing until the frame ends. When a write frame closes, the buffer is copied into one page of the array.

All pins are sampled by the block's own clock through synchronizers. The serial clock must therefore run well below that clock: each serial-clock half period should last at least six block clocks. A separate active-low hardware reset input is filtered for a minimum length. A qualifying pulse abandons the current frame, releases the lines, clears the bank register and refills the program buffer with ones. The array contents stay. After any reset, no command is taken until the select line has gone high and then low again.

Top module: `mlane_spi_front`

## Requirements
- R1: A command is the first eight serial-clock rising edges after select falls, sampled on io_in[0] most significant bit first. Opcodes: 0x03 single read, 0x3B two-line output read, 0x6B four-line output read, 0xBB two-line address-and-data read, 0xEB four-line address-and-data read, 0x02 buffer write, 0x17 bank register write.
- R2: With 0x03 the 24-bit address arrives on io_in[0] over 24 rising edges. Each data byte leaves on io_out[1] most significant bit first. io_oe reads 4'b0010 during the data phase.
- R3: With 0x3B and 0x6B the address arrives on io_in[0]. Data leaves as pairs on io_out[1:0] or as nibbles on io_out[3:0], with io_oe 4'b0011 or 4'b1111. In each group the highest-numbered line carries the most significant bit, and the upper group goes first.
- R4: With 0xBB the address arrives as pairs on io_in[1:0] over 12 rising edges. With 0xEB it arrives as nibbles on io_in[3:0] over 6 edges. In both cases the highest-numbered line is most significant. Data then leaves as for 0x3B and 0x6B respectively.
- R5: Output data changes only after a serial-clock falling edge. The first group of a read appears after the falling edge that follows the rising edge of the last address group. It is held through the next high half period.
- R6: A byte is fetched from array index {bank, address[4:0]}, and the upper address bits are ignored. After each complete byte the address steps by one and wraps within its 32-byte page.
- R7: When select goes high, io_oe drops to zero at once and the frame is abandoned. Serial-clock activity while select is high has no effect.
- R8: After the reset input or a qualifying hardware reset, commands are ignored until a falling edge of select is seen.
- R9: An unrecognised opcode leaves io_oe at zero for the rest of the frame. The next frame is decoded normally.
- R10: With 0x02 the address and data arrive on io_in[0], and each complete byte goes to the buffer at the running address. When select rises after at least one complete byte, the buffer is copied into the current bank's page and the buffer is refilled with 0xFF. A trailing partial byte is dropped.
- R11: With 0x17 the next byte, on io_in[0], loads its low bit into the bank register. Any further edges in that frame are ignored.
- R12: hw_rst_n held low for at least RST_MIN_CYC clocks abandons the frame without committing it. It zeroes io_oe and the bank register and refills the buffer with 0xFF. A shorter low pulse has no effect.
- R13: The reset input sets array byte i to (i*37 + 11) mod 256 and sets the bank to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to oversample all pins |
| rst | input | 1 | Synchronous active-high power-on reset |
| hw_rst_n | input | 1 | Active-low hardware reset, length-filtered |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low frame select |
| io_in | input | 4 | Data lines as seen from the pins |
| io_out | output | 4 | Data driven towards the host |
| io_oe | output | 4 | Per-line output enable |

## Verification
The hardest state to reach is a hardware reset that lands inside a write frame, after a byte has entered the buffer but before select rises. Only a later commit shows whether that byte was discarded. The stimulus writes a byte into bank one's buffer and holds hw_rst_n low mid-frame. It then keeps clocking a command under the same select to show it is refused. Finally it runs a fresh one-byte write in bank zero and reads the page back. The untouched neighbouring byte must come back as 0xFF, not as the aborted value.

// File: rtl/mlsf_pkg.sv
package mlsf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_ADDR, ST_BANK, ST_WDATA, ST_RDATA, ST_DEAD
  } st_e;

  typedef enum logic [1:0] {LN_1 = 2'd0, LN_2 = 2'd1, LN_4 = 2'd2} lane_e;

  typedef struct packed {
    logic  is_read;
    lane_e addr_ln;
    lane_e data_ln;
  } mode_t;

  typedef struct packed {
    logic  valid;
    logic  is_bank;
    mode_t mode;
  } cmd_t;

  localparam logic [7:0] OP_RD1    = 8'h03;
  localparam logic [7:0] OP_RD_O2  = 8'h3B;
  localparam logic [7:0] OP_RD_O4  = 8'h6B;
  localparam logic [7:0] OP_RD_IO2 = 8'hBB;
  localparam logic [7:0] OP_RD_IO4 = 8'hEB;
  localparam logic [7:0] OP_PROG   = 8'h02;
  localparam logic [7:0] OP_BANK   = 8'h17;

  function automatic cmd_t decode(input logic [7:0] op);
    cmd_t c;
    c = '0;
    c.valid = 1'b1;
    unique case (op)
      OP_RD1:    c.mode = '{is_read: 1'b1, addr_ln: LN_1, data_ln: LN_1};
      OP_RD_O2:  c.mode = '{is_read: 1'b1, addr_ln: LN_1, data_ln: LN_2};
      OP_RD_O4:  c.mode = '{is_read: 1'b1, addr_ln: LN_1, data_ln: LN_4};
      OP_RD_IO2: c.mode = '{is_read: 1'b1, addr_ln: LN_2, data_ln: LN_2};
      OP_RD_IO4: c.mode = '{is_read: 1'b1, addr_ln: LN_4, data_ln: LN_4};
      OP_PROG:   c.mode = '{is_read: 1'b0, addr_ln: LN_1, data_ln: LN_1};
      OP_BANK:   c.is_bank = 1'b1;
      default:   c.valid = 1'b0;
    endcase
    return c;
  endfunction

  // Power-on contents of array byte idx
  function automatic logic [7:0] init_byte(input int unsigned idx);
    return 8'((idx * 37 + 11) % 256);
  endfunction

endpackage

// File: rtl/mlsf_sync.sv
module mlsf_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg <= {STAGES{RST_VAL}};
    else     stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/mlsf_rst_filter.sv
module mlsf_rst_filter #(
  parameter int MIN_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic n_in,
  output logic hit
);
  localparam int CW = $clog2(MIN_CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || n_in)                cnt <= '0;
    else if (cnt != CW'(MIN_CYC))   cnt <= cnt + CW'(1);
  end

  assign hit = (cnt == CW'(MIN_CYC));
endmodule

// File: rtl/mlsf_store.sv
module mlsf_store
  import mlsf_pkg::*;
#(
  parameter int PAGE_W = 5,
  parameter int BANK_W = 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clr_buf,
  input  logic [PAGE_W+BANK_W-1:0]  rd_idx,
  output logic [7:0]                rd_data,
  input  logic                      pb_we,
  input  logic [PAGE_W-1:0]         pb_idx,
  input  logic [7:0]                pb_data,
  input  logic                      commit,
  input  logic [BANK_W-1:0]         commit_bank
);
  localparam int IDX_W   = PAGE_W + BANK_W;
  localparam int PAGE_SZ = 1 << PAGE_W;
  localparam int DEPTH   = 1 << IDX_W;

  logic [7:0] mem  [DEPTH];
  logic [7:0] pbuf [PAGE_SZ];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= init_byte(i);
    end else if (commit) begin
      for (int j = 0; j < PAGE_SZ; j++) mem[{commit_bank, PAGE_W'(j)}] <= pbuf[j];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_buf) begin
      for (int j = 0; j < PAGE_SZ; j++) pbuf[j] <= 8'hFF;
    end else if (pb_we) begin
      pbuf[pb_idx] <= pb_data;
    end
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/mlane_spi_front.sv
module mlane_spi_front
  import mlsf_pkg::*;
#(
  parameter int PAGE_W      = 5,
  parameter int BANK_W      = 1,
  parameter int RST_MIN_CYC = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hw_rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic [3:0] io_in,
  output logic [3:0] io_out,
  output logic [3:0] io_oe
);
  localparam int IDX_W = PAGE_W + BANK_W;

  // Pin synchronisation: {hw_rst_n, cs_n, sck, io[3:0]}
  logic       hw_n_s, cs_s, sck_s;
  logic [3:0] io_s;

  mlsf_sync #(.W(7), .STAGES(SYNC_STAGES), .RST_VAL(7'b100_0000)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({hw_rst_n, cs_n, sck, io_in}),
    .q   ({hw_n_s, cs_s, sck_s, io_s})
  );

  logic hrst;
  mlsf_rst_filter #(.MIN_CYC(RST_MIN_CYC)) u_rflt (
    .clk  (clk),
    .rst  (rst),
    .n_in (hw_n_s),
    .hit  (hrst)
  );

  // Edge detection (cs_q resets low so a genuine rise then fall is needed)
  logic cs_q, sck_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q  <= 1'b0;
      sck_q <= 1'b0;
    end else begin
      cs_q  <= cs_s;
      sck_q <= sck_s;
    end
  end

  logic cs_fall, cs_rise, sck_rise, sck_fall;
  assign cs_fall  = cs_q & ~cs_s;
  assign cs_rise  = ~cs_q & cs_s;
  assign sck_rise = ~sck_q & sck_s;
  assign sck_fall = sck_q & ~sck_s;

  // Protocol state
  st_e               st;
  logic [4:0]        cnt;
  logic [7:0]        sh;
  logic [PAGE_W-1:0] addr_q;
  logic [BANK_W-1:0] bank_q;
  mode_t             mode_q;
  logic [2:0]        gidx;
  logic              wrote_q;
  logic [3:0]        out_q, oe_q;

  logic [7:0] in_byte;
  cmd_t       dec;
  assign in_byte = {sh[6:0], io_s[0]};
  assign dec     = decode(in_byte);

  // Lane-dependent limits and output group selection
  logic [4:0] addr_last;
  logic [2:0] grp_last;
  logic [3:0] oe_pat, grp;
  logic [7:0] rd_data, rot;

  always_comb begin
    unique case (mode_q.addr_ln)
      LN_1:    addr_last = 5'd23;
      LN_2:    addr_last = 5'd11;
      default: addr_last = 5'd5;
    endcase
    unique case (mode_q.data_ln)
      LN_1: begin
        grp_last = 3'd7;
        oe_pat   = 4'b0010;
        rot      = rd_data << gidx;
        grp      = {2'b00, rot[7], 1'b0};
      end
      LN_2: begin
        grp_last = 3'd3;
        oe_pat   = 4'b0011;
        rot      = rd_data << {gidx[1:0], 1'b0};
        grp      = {2'b00, rot[7:6]};
      end
      default: begin
        grp_last = 3'd1;
        oe_pat   = 4'b1111;
        rot      = gidx[0] ? {rd_data[3:0], 4'h0} : rd_data;
        grp      = rot[7:4];
      end
    endcase
  end

  logic pb_we, commit;
  assign pb_we  = !hrst && !cs_s && (st == ST_WDATA) && sck_rise && (cnt == 5'd7);
  assign commit = !hrst && cs_rise && (st == ST_WDATA) && wrote_q;

  mlsf_store #(.PAGE_W(PAGE_W), .BANK_W(BANK_W)) u_store (
    .clk         (clk),
    .rst         (rst),
    .clr_buf     (hrst | commit),
    .rd_idx      ({bank_q, addr_q}),
    .rd_data     (rd_data),
    .pb_we       (pb_we),
    .pb_idx      (addr_q),
    .pb_data     (in_byte),
    .commit      (commit),
    .commit_bank (bank_q)
  );

  always_ff @(posedge clk) begin
    if (rst || hrst) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      sh      <= '0;
      addr_q  <= '0;
      bank_q  <= '0;
      mode_q  <= '0;
      gidx    <= '0;
      wrote_q <= 1'b0;
      out_q   <= '0;
      oe_q    <= '0;
    end else if (cs_s) begin
      st   <= ST_IDLE;
      oe_q <= '0;
    end else if (cs_fall) begin
      st      <= ST_CMD;
      cnt     <= '0;
      gidx    <= '0;
      wrote_q <= 1'b0;
    end else begin
      unique case (st)
        ST_CMD: if (sck_rise) begin
          sh  <= in_byte;
          cnt <= cnt + 5'd1;
          if (cnt == 5'd7) begin
            cnt    <= '0;
            mode_q <= dec.mode;
            if (!dec.valid)       st <= ST_DEAD;
            else if (dec.is_bank) st <= ST_BANK;
            else                  st <= ST_ADDR;
          end
        end
        ST_ADDR: if (sck_rise) begin
          unique case (mode_q.addr_ln)
            LN_1:    addr_q <= PAGE_W'({addr_q, io_s[0]});
            LN_2:    addr_q <= PAGE_W'({addr_q, io_s[1:0]});
            default: addr_q <= PAGE_W'({addr_q, io_s});
          endcase
          cnt <= cnt + 5'd1;
          if (cnt == addr_last) begin
            cnt <= '0;
            st  <= mode_q.is_read ? ST_RDATA : ST_WDATA;
          end
        end
        ST_BANK: if (sck_rise) begin
          sh  <= in_byte;
          cnt <= cnt + 5'd1;
          if (cnt == 5'd7) begin
            bank_q <= BANK_W'(in_byte);
            st     <= ST_DEAD;
          end
        end
        ST_WDATA: if (sck_rise) begin
          sh  <= in_byte;
          cnt <= cnt + 5'd1;
          if (cnt == 5'd7) begin
            cnt     <= '0;
            addr_q  <= addr_q + PAGE_W'(1);
            wrote_q <= 1'b1;
          end
        end
        ST_RDATA: if (sck_fall) begin
          out_q <= grp;
          oe_q  <= oe_pat;
          if (gidx == grp_last) begin
            gidx   <= '0;
            addr_q <= addr_q + PAGE_W'(1);
          end else begin
            gidx <= gidx + 3'd1;
          end
        end
        default: ;
      endcase
    end
  end

  assign io_out = out_q;
  assign io_oe  = oe_q & {4{~cs_n}};
endmodule

// File: rtl/mlane_spi_front_chk.sv
module mlane_spi_front_chk
  import mlsf_pkg::*;
#(
  parameter int BANK_W = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              hrst,
  input logic              cs_fall,
  input logic              sck_fall,
  input st_e               st,
  input logic [BANK_W-1:0] bank,
  input logic [3:0]        io_oe,
  input logic [3:0]        io_out
);
  // R2/R3: only the lane patterns of the read commands may be enabled
  p_oe_legal_r3: assert property (@(posedge clk) disable iff (rst)
    (io_oe == 4'h0 || io_oe == 4'b0010 || io_oe == 4'b0011 || io_oe == 4'b1111));

  // R5: the data lines move only after a serial-clock falling edge
  p_out_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
    (!sck_fall && !hrst) |=> $stable(io_out));

  // R9: lines are driven only in the read data phase
  p_oe_read_only_r9: assert property (@(posedge clk) disable iff (rst)
    (io_oe != 4'h0) |-> (st == ST_RDATA));

  // R8: standby is left only through a select falling edge
  p_idle_until_fall_r8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && !cs_fall) |=> (st == ST_IDLE));

  // R12: a qualifying hardware reset clears the bank and releases the lines
  p_hrst_clears_r12: assert property (@(posedge clk) disable iff (rst)
    hrst |=> (bank == '0 && io_oe == 4'h0 && st == ST_IDLE));
endmodule

bind mlane_spi_front mlane_spi_front_chk #(.BANK_W(BANK_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .hrst     (hrst),
  .cs_fall  (cs_fall),
  .sck_fall (sck_fall),
  .st       (st),
  .bank     (bank_q),
  .io_oe    (io_oe),
  .io_out   (io_out)
);

// File: tb/sim_mlane_spi_front.sv
module sim_mlane_spi_front;
  localparam int PAGE_W = 5;
  localparam int BANK_W = 1;
  localparam int RST_MIN = 16;
  localparam int HP = 6;

  logic clk = 1'b0, rst = 1'b1, hw_rst_n = 1'b1, sck = 1'b0, cs_n = 1'b1;
  logic [3:0] io_in = 4'h0;
  wire  [3:0] io_out, io_oe;

  always #4 clk = ~clk;

  mlane_spi_front #(.PAGE_W(PAGE_W), .BANK_W(BANK_W), .RST_MIN_CYC(RST_MIN)) u0 (
    .clk(clk), .rst(rst), .hw_rst_n(hw_rst_n), .sck(sck), .cs_n(cs_n),
    .io_in(io_in), .io_out(io_out), .io_oe(io_oe)
  );

  int checks = 0, fails = 0;
  logic [7:0] model [64];
  int bank_m = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic [3:0] din, output logic [3:0] dpre, output logic [3:0] oepre,
                       output logic [3:0] dhi);
    io_in = din;
    wclk(HP);
    dpre = io_out; oepre = io_oe;
    sck = 1'b1;
    wclk(HP);
    dhi = io_out;
    sck = 1'b0;
  endtask

  task automatic send8(input logic [7:0] b);
    logic [3:0] a, o, h;
    for (int i = 0; i < 8; i++) pulse({3'b000, b[7-i]}, a, o, h);
  endtask

  task automatic send_addr(input logic [23:0] adr, input int ln);
    logic [3:0] a, o, h, v;
    for (int k = 0; k < 24 / ln; k++) begin
      v = 4'((adr >> (24 - ln * (k + 1))) & ((1 << ln) - 1));
      pulse(v, a, o, h);
    end
  endtask

  task automatic begin_frame();
    cs_n = 1'b0;
    wclk(HP);
  endtask

  task automatic end_frame();
    wclk(HP);
    cs_n = 1'b1;
    wclk(2 * HP);
  endtask

  function automatic logic [3:0] oe_for(input int ln);
    return (ln == 1) ? 4'b0010 : (ln == 2) ? 4'b0011 : 4'b1111;
  endfunction

  task automatic get_byte(input int ln, output logic [7:0] b, output logic [3:0] oe0, output bit steady);
    logic [3:0] dp, op, dh;
    b = 8'h00; steady = 1'b1; oe0 = 4'h0;
    for (int g = 0; g < 8 / ln; g++) begin
      pulse(4'h0, dp, op, dh);
      if (g == 0) oe0 = op;
      else if (op !== oe0) steady = 1'b0;
      if (dh !== dp) steady = 1'b0;
      case (ln)
        1:       b = {b[6:0], dp[1]};
        2:       b = {b[5:0], dp[1:0]};
        default: b = {b[3:0], dp};
      endcase
    end
  endtask

  function automatic int midx(input logic [23:0] adr, input int k);
    return bank_m * 32 + ((int'(adr[4:0]) + k) % 32);
  endfunction

  task automatic read_bytes(input logic [23:0] adr, input int first, input int n, input int ln, input string req);
    logic [7:0] b; logic [3:0] oe0; bit st;
    for (int k = first; k < first + n; k++) begin
      get_byte(ln, b, oe0, st);
      chk(b === model[midx(adr, k)], req, "read byte", int'(b), int'(model[midx(adr, k)]));
      chk(oe0 === oe_for(ln), req, "output enable", int'(oe0), int'(oe_for(ln)));
      chk(st, "R5", "data held over rising edge", 0, 1);
    end
  endtask

  task automatic do_read(input logic [7:0] op, input int la, input int ld, input logic [23:0] adr,
                         input int n, input string req);
    begin_frame();
    send8(op);
    send_addr(adr, la);
    read_bytes(adr, 0, n, ld, req);
    end_frame();
  endtask

  task automatic do_write(input logic [23:0] adr, input logic [7:0] d0, input logic [7:0] d1,
                          input int n, input int partial);
    logic [3:0] a, o, h;
    begin_frame();
    send8(8'h02);
    send_addr(adr, 1);
    if (n > 0) send8(d0);
    if (n > 1) send8(d1);
    for (int p = 0; p < partial; p++) pulse(4'h1, a, o, h);
    end_frame();
    if (n > 0) begin
      for (int j = 0; j < 32; j++) model[bank_m * 32 + j] = 8'hFF;
      model[midx(adr, 0)] = d0;
      if (n > 1) model[midx(adr, 1)] = d1;
    end
  endtask

  task automatic set_bank(input logic [7:0] v);
    begin_frame();
    send8(8'h17);
    send8(v);
    send8(8'h00);
    end_frame();
    bank_m = int'(v[0]);
  endtask

  // R8 and reset state: select held low through reset, command refused
  task automatic t_reset_state();
    logic [3:0] a, o, h; bit any_oe;
    cs_n = 1'b0;
    rst = 1'b1;
    wclk(5);
    rst = 1'b0;
    wclk(4);
    chk(io_oe === 4'h0, "R7", "oe after reset", int'(io_oe), 0);
    send8(8'h03);
    send_addr(24'h0, 1);
    any_oe = 1'b0;
    for (int i = 0; i < 16; i++) begin
      pulse(4'h0, a, o, h);
      if (o !== 4'h0) any_oe = 1'b1;
    end
    chk(!any_oe, "R8", "command without select edge drives lines", int'(any_oe), 0);
    cs_n = 1'b1;
    wclk(2 * HP);
  endtask

  task automatic t_single_read();
    do_read(8'h03, 1, 1, 24'h000003, 4, "R2 R1 R13");
  endtask

  task automatic t_output_reads();
    do_read(8'h3B, 1, 2, 24'h000010, 3, "R3 dual");
    do_read(8'h6B, 1, 4, 24'h000007, 3, "R3 quad");
  endtask

  task automatic t_io_reads();
    do_read(8'hBB, 2, 2, 24'h00001A, 3, "R4 dual");
    do_read(8'hEB, 4, 4, 24'h000015, 3, "R4 quad");
  endtask

  task automatic t_wrap();
    do_read(8'h03, 1, 1, 24'hFFFFFE, 4, "R6");
  endtask

  task automatic t_cs_abort();
    logic [3:0] a, o, h;
    begin_frame();
    send8(8'h6B);
    send_addr(24'h000008, 1);
    read_bytes(24'h000008, 0, 1, 4, "R7");
    cs_n = 1'b1;
    wclk(1);
    chk(io_oe === 4'h0, "R7", "oe right after select rises", int'(io_oe), 0);
    for (int i = 0; i < 10; i++) pulse(4'h1, a, o, h);
    wclk(HP);
    do_read(8'h03, 1, 1, 24'h000009, 2, "R7 after ignored clocks");
  endtask

  task automatic t_unknown();
    logic [3:0] a, o, h; bit any_oe;
    begin_frame();
    send8(8'h55);
    any_oe = 1'b0;
    for (int i = 0; i < 40; i++) begin
      pulse(4'h0, a, o, h);
      if (o !== 4'h0) any_oe = 1'b1;
    end
    chk(!any_oe, "R9", "unknown opcode drives lines", int'(any_oe), 0);
    end_frame();
    do_read(8'h3B, 1, 2, 24'h000001, 2, "R9 next frame");
  endtask

  task automatic t_program();
    do_write(24'h000004, 8'hC3, 8'h3C, 2, 5);
    do_read(8'h03, 1, 1, 24'h000002, 6, "R10");
  endtask

  task automatic t_bank();
    set_bank(8'h01);
    do_read(8'h03, 1, 1, 24'h000005, 2, "R11 bank one");
    do_write(24'h000000, 8'h77, 8'h00, 1, 0);
    do_read(8'h6B, 1, 4, 24'h00001F, 3, "R11 write in bank one");
  endtask

  task automatic t_hw_reset();
    logic [3:0] a, o, h; bit any_oe;
    // short pulse during a read is ignored
    begin_frame();
    send8(8'h03);
    send_addr(24'h000002, 1);
    read_bytes(24'h000002, 0, 1, 1, "R12");
    hw_rst_n = 1'b0; wclk(RST_MIN - 3); hw_rst_n = 1'b1;
    read_bytes(24'h000002, 1, 2, 1, "R12 short pulse ignored");
    // qualifying pulse in a write frame
    end_frame();
    begin_frame();
    send8(8'h02);
    send_addr(24'h000000, 1);
    send8(8'h11);
    hw_rst_n = 1'b0; wclk(RST_MIN + 4);
    chk(io_oe === 4'h0, "R12", "oe during hardware reset", int'(io_oe), 0);
    hw_rst_n = 1'b1; wclk(4);
    bank_m = 0;
    send8(8'h03);
    send_addr(24'h000000, 1);
    any_oe = 1'b0;
    for (int i = 0; i < 16; i++) begin
      pulse(4'h0, a, o, h);
      if (o !== 4'h0) any_oe = 1'b1;
    end
    chk(!any_oe, "R8", "command accepted without new select edge", int'(any_oe), 0);
    end_frame();
    do_read(8'h03, 1, 1, 24'h000000, 2, "R12 bank zero and no commit");
    do_write(24'h000001, 8'h22, 8'h00, 1, 0);
    do_read(8'hEB, 4, 4, 24'h000000, 3, "R12 buffer refilled");
  endtask

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 8'((i * 37 + 11) % 256);
    wclk(2);
    t_reset_state();
    t_single_read();
    t_output_reads();
    t_io_reads();
    t_wrap();
    t_cs_abort();
    t_unknown();
    t_program();
    t_bank();
    t_hw_reset();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule